// File: doc/BRIEF.md
# Configuration Register Lock Sequencer

This block protects the per-pin configuration fields of a 16-pin port from later modification. Software arms the protection through a dedicated lock register using a fixed three-write, one-read key sequence in which every write carries the same 16-bit pin mask. Once armed, the mask is frozen. Every pin selected by it has its fields in the six configuration registers made read-only until the next reset. These are the direction/mode, output type, drive speed, pull, and the low and high alternate-function selector registers.

The configuration registers themselves live outside the block. For each write on the register port, the block produces one 32-bit bit-level write mask per configuration register. The mask is non-zero only for the addressed register. It combines the byte lanes given by the access size with the fields of pins that are still open. It also outputs the per-pin locked vector, and it answers reads of the lock register with the key status and the frozen mask.

The register port uses a 3-bit register index: 0 mode, 1 output type, 2 speed, 3 pull, 4 lock, 5 low alternate function, 6 high alternate function, 7 unused. The size code is 0 for a byte (bits 7:0), 1 for a half-word (bits 15:0), 2 for a full word, and 3 for no lanes.

Top module: `cfg_lock_unit`

## Requirements
- R1: After reset the locked vector is zero and a read of the lock register (index 4) returns zero.
- R2: Until the lock is armed, every read of the lock register returns zero, including the read that arms it. After arming, a read returns bit 16 set, the frozen mask in bits 15:0 and zeros elsewhere.
- R3: The lock arms when these lock-register accesses occur in order: a word write with bit 16 = 1, a word write with bit 16 = 0, a word write with bit 16 = 1, then a read. From the cycle after that read, the locked vector equals the mask from bits 15:0.
- R4: A word write during the sequence whose bits 15:0 differ from the mask of the first write returns the sequencer to idle, and no lock arms.
- R5: A byte or half-word write to the lock register returns the sequencer to idle, and no lock arms.
- R6: An access out of order returns the sequencer to idle without locking. This covers a read before the third write, a write where a read is due, and a key bit of the wrong value.
- R7: Accesses to the other register indices between sequence steps neither advance nor abort the sequence.
- R8: For a locked pin i, the write masks never cover its fields. In the mode, speed and pull registers the fields are bits 2i+1:2i. In the output-type register the field is bit i. In the low alternate-function register (pins 0–7) the field is bits 4i+3:4i, and in the high alternate-function register (pins 8–15) it is bits 4(i−8)+3:4(i−8).
- R9: For an open pin, the write mask of the addressed register covers its fields within the byte lanes selected by the size code. The output-type mask never covers bits 31:16.
- R10: Once armed, the locked vector and the lock read value stay fixed. Further writes to the lock register and new key sequences have no effect, and only reset clears the lock.
- R11: At most one of the six write masks is non-zero in any cycle. All are zero when no write is presented or when the lock register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access presented this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_size | input | 2 | Access size code |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Lock register read data (zero for other indices) |
| pin_locked | output | 16 | Per-pin locked vector |
| mode_wmask | output | 32 | Bit write mask for the mode register |
| otype_wmask | output | 32 | Bit write mask for the output-type register |
| speed_wmask | output | 32 | Bit write mask for the speed register |
| pull_wmask | output | 32 | Bit write mask for the pull register |
| aflo_wmask | output | 32 | Bit write mask for the low alternate-function register |
| afhi_wmask | output | 32 | Bit write mask for the high alternate-function register |

## Verification
The hardest cases to reach are the aborted sequences. From the ports they look exactly like a sequence that never started, because the read data stays zero until the lock arms. The bench therefore ends every abort scenario with an extra read and a set of configuration writes. These prove that no pin became locked and that the sequencer did not sit half-armed. A complete sequence is also run with writes to other registers interleaved between its steps. A later attempt to re-arm with a different mask confirms that the first mask stays frozen.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned KEY_BIT   = 16;

  localparam logic [REG_IDX_W-1:0] IDX_MODE  = 3'd0;
  localparam logic [REG_IDX_W-1:0] IDX_OTYPE = 3'd1;
  localparam logic [REG_IDX_W-1:0] IDX_SPEED = 3'd2;
  localparam logic [REG_IDX_W-1:0] IDX_PULL  = 3'd3;
  localparam logic [REG_IDX_W-1:0] IDX_LOCK  = 3'd4;
  localparam logic [REG_IDX_W-1:0] IDX_AFLO  = 3'd5;
  localparam logic [REG_IDX_W-1:0] IDX_AFHI  = 3'd6;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    SEQ_IDLE  = 3'd0,
    SEQ_KEY1  = 3'd1,
    SEQ_KEY0  = 3'd2,
    SEQ_KEY2  = 3'd3,
    SEQ_ARMED = 3'd4
  } seq_e;

endpackage

// File: rtl/cfg_lock_rst_sync.sv
module cfg_lock_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/cfg_lock_seq.sv
module cfg_lock_seq
  import cfg_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             wr_i,
  input  logic             word_i,
  input  logic             key_i,
  input  logic [NPINS-1:0] mask_i,
  output seq_e             state_o,
  output logic [NPINS-1:0] mask_o,
  output logic [NPINS-1:0] locked_o
);

  seq_e             st_q, st_d;
  logic [NPINS-1:0] mask_q;
  logic             cap_en;
  logic             same_mask;
  logic             good_wr;

  assign same_mask = (mask_i == mask_q);
  assign good_wr   = wr_i && word_i;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    if (acc_i) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (good_wr && key_i) begin
            st_d   = SEQ_KEY1;
            cap_en = 1'b1;
          end else begin
            st_d = SEQ_IDLE;
          end
        end
        SEQ_KEY1:  st_d = (good_wr && !key_i && same_mask) ? SEQ_KEY0 : SEQ_IDLE;
        SEQ_KEY0:  st_d = (good_wr &&  key_i && same_mask) ? SEQ_KEY2 : SEQ_IDLE;
        SEQ_KEY2:  st_d = (!wr_i) ? SEQ_ARMED : SEQ_IDLE;
        SEQ_ARMED: st_d = SEQ_ARMED;
        default:   st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEQ_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (cap_en) begin
      mask_q <= mask_i;
    end
  end

  assign state_o  = st_q;
  assign mask_o   = mask_q;
  assign locked_o = (st_q == SEQ_ARMED) ? mask_q : '0;

endmodule

// File: rtl/cfg_lock_fieldmask.sv
module cfg_lock_fieldmask #(
  parameter int unsigned NPINS = 16,
  localparam int unsigned HALF = NPINS / 2
) (
  input  logic [NPINS-1:0]  locked_i,
  output logic [2*NPINS-1:0] open_two_o,
  output logic [NPINS-1:0]   open_one_o,
  output logic [4*HALF-1:0]  open_aflo_o,
  output logic [4*HALF-1:0]  open_afhi_o
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    assign open_two_o[2*p +: 2] = {2{~locked_i[p]}};
    assign open_one_o[p]        = ~locked_i[p];
  end

  for (genvar q = 0; q < HALF; q++) begin : g_af
    assign open_aflo_o[4*q +: 4] = {4{~locked_i[q]}};
    assign open_afhi_o[4*q +: 4] = {4{~locked_i[HALF+q]}};
  end

endmodule

// File: rtl/cfg_lock_unit.sv
module cfg_lock_unit
  import cfg_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [REG_IDX_W-1:0] bus_addr,
  input  logic [1:0]           bus_size,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic [NPINS-1:0]     pin_locked,
  output logic [DW-1:0]        mode_wmask,
  output logic [DW-1:0]        otype_wmask,
  output logic [DW-1:0]        speed_wmask,
  output logic [DW-1:0]        pull_wmask,
  output logic [DW-1:0]        aflo_wmask,
  output logic [DW-1:0]        afhi_wmask
);

  localparam int unsigned HALF = NPINS / 2;

  logic             rst_sync_n;
  logic             lock_acc;
  logic             is_word;
  seq_e             seq_st;
  logic [NPINS-1:0] seq_mask;
  logic [NPINS-1:0] locked;

  logic [2*NPINS-1:0] open_two;
  logic [NPINS-1:0]   open_one;
  logic [4*HALF-1:0]  open_aflo;
  logic [4*HALF-1:0]  open_afhi;

  logic [DW-1:0] lanes;
  logic [DW-1:0] pad_two, pad_one, pad_aflo, pad_afhi;
  logic          cfg_wr;
  logic          unused_wdata;

  assign unused_wdata = ^{1'b0, bus_wdata[DW-1:KEY_BIT+1]};

  cfg_lock_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign lock_acc = bus_valid && (bus_addr == IDX_LOCK);
  assign is_word  = (bus_size == SZ_WORD);

  cfg_lock_seq #(.NPINS(NPINS)) i_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .acc_i    (lock_acc),
    .wr_i     (bus_write),
    .word_i   (is_word),
    .key_i    (bus_wdata[KEY_BIT]),
    .mask_i   (bus_wdata[NPINS-1:0]),
    .state_o  (seq_st),
    .mask_o   (seq_mask),
    .locked_o (locked)
  );

  cfg_lock_fieldmask #(.NPINS(NPINS)) i_fieldmask (
    .locked_i    (locked),
    .open_two_o  (open_two),
    .open_one_o  (open_one),
    .open_aflo_o (open_aflo),
    .open_afhi_o (open_afhi)
  );

  always_comb begin
    lanes = '0;
    unique case (bus_size)
      SZ_BYTE: lanes[7:0]  = '1;
      SZ_HALF: lanes[15:0] = '1;
      SZ_WORD: lanes       = '1;
      default: lanes       = '0;
    endcase
  end

  always_comb begin
    pad_two  = '0;
    pad_one  = '0;
    pad_aflo = '0;
    pad_afhi = '0;
    pad_two[2*NPINS-1:0] = open_two;
    pad_one[NPINS-1:0]   = open_one;
    pad_aflo[4*HALF-1:0] = open_aflo;
    pad_afhi[4*HALF-1:0] = open_afhi;
  end

  assign cfg_wr = bus_valid && bus_write;

  assign mode_wmask  = (cfg_wr && bus_addr == IDX_MODE)  ? (lanes & pad_two)  : '0;
  assign otype_wmask = (cfg_wr && bus_addr == IDX_OTYPE) ? (lanes & pad_one)  : '0;
  assign speed_wmask = (cfg_wr && bus_addr == IDX_SPEED) ? (lanes & pad_two)  : '0;
  assign pull_wmask  = (cfg_wr && bus_addr == IDX_PULL)  ? (lanes & pad_two)  : '0;
  assign aflo_wmask  = (cfg_wr && bus_addr == IDX_AFLO)  ? (lanes & pad_aflo) : '0;
  assign afhi_wmask  = (cfg_wr && bus_addr == IDX_AFHI)  ? (lanes & pad_afhi) : '0;

  always_comb begin
    bus_rdata = '0;
    if (lock_acc && !bus_write && (seq_st == SEQ_ARMED)) begin
      bus_rdata[KEY_BIT]     = 1'b1;
      bus_rdata[NPINS-1:0]   = locked;
    end
  end

  assign pin_locked = locked;

endmodule

// File: rtl/cfg_lock_chk.sv
module cfg_lock_chk
  import cfg_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [REG_IDX_W-1:0] bus_addr,
  input logic [1:0]           bus_size,
  input logic [DW-1:0]        bus_wdata,
  input logic [NPINS-1:0]     pin_locked,
  input logic [DW-1:0]        mode_wmask,
  input logic [DW-1:0]        otype_wmask,
  input logic [DW-1:0]        aflo_wmask,
  input logic [DW-1:0]        afhi_wmask,
  input logic [DW-1:0]        speed_wmask,
  input logic [DW-1:0]        pull_wmask,
  input seq_e                 seq_st,
  input logic [NPINS-1:0]     seq_mask
);

  localparam int unsigned HALF = NPINS / 2;

  logic          lock_acc;
  logic [DW-1:0] lk_two, lk_aflo, lk_afhi, lk_one;

  assign lock_acc = bus_valid && (bus_addr == IDX_LOCK);

  always_comb begin
    lk_two  = '0;
    lk_one  = '0;
    lk_aflo = '0;
    lk_afhi = '0;
    for (int p = 0; p < NPINS; p++) begin
      lk_two[2*p]   = pin_locked[p];
      lk_two[2*p+1] = pin_locked[p];
      lk_one[p]     = pin_locked[p];
    end
    for (int q = 0; q < HALF; q++) begin
      for (int b = 0; b < 4; b++) begin
        lk_aflo[4*q+b] = pin_locked[q];
        lk_afhi[4*q+b] = pin_locked[HALF+q];
      end
    end
  end

  // R3
  arm_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_acc && !bus_write && seq_st == SEQ_KEY2) |=> (seq_st == SEQ_ARMED));

  // R4
  mask_change_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_acc && bus_write && (seq_st == SEQ_KEY1 || seq_st == SEQ_KEY0) &&
     bus_wdata[NPINS-1:0] != seq_mask) |=> (seq_st == SEQ_IDLE));

  // R5
  narrow_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_acc && bus_write && bus_size != SZ_WORD && seq_st != SEQ_ARMED)
    |=> (seq_st == SEQ_IDLE));

  // R8
  locked_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_wmask & lk_two) == '0) && ((speed_wmask & lk_two) == '0) &&
    ((pull_wmask & lk_two) == '0) && ((otype_wmask & lk_one) == '0) &&
    ((aflo_wmask & lk_aflo) == '0) && ((afhi_wmask & lk_afhi) == '0));

  // R10
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == SEQ_ARMED) |=> (seq_st == SEQ_ARMED) && $stable(pin_locked));

  // R11
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|mode_wmask, |otype_wmask, |speed_wmask, |pull_wmask,
              |aflo_wmask, |afhi_wmask}));

endmodule

bind cfg_lock_unit cfg_lock_chk #(.NPINS(NPINS), .DW(DW)) i_cfg_lock_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_size    (bus_size),
  .bus_wdata   (bus_wdata),
  .pin_locked  (pin_locked),
  .mode_wmask  (mode_wmask),
  .otype_wmask (otype_wmask),
  .aflo_wmask  (aflo_wmask),
  .afhi_wmask  (afhi_wmask),
  .speed_wmask (speed_wmask),
  .pull_wmask  (pull_wmask),
  .seq_st      (seq_st),
  .seq_mask    (seq_mask)
);

// File: tb/test_cfg_lock_unit.sv
`timescale 1ns/1ps
module test_cfg_lock_unit;

  logic        clk;
  logic        rst_n;
  logic        bus_valid;
  logic        bus_write;
  logic [2:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] pin_locked;
  logic [31:0] wm [0:6];

  int n_chk;
  int n_fail;

  logic [31:0] cfg_q [0:6];
  logic [31:0] cfg_exp [0:6];
  logic [15:0] exp_lock;

  cfg_lock_unit i_cfg_lock_unit (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_size    (bus_size),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .pin_locked  (pin_locked),
    .mode_wmask  (wm[0]),
    .otype_wmask (wm[1]),
    .speed_wmask (wm[2]),
    .pull_wmask  (wm[3]),
    .aflo_wmask  (wm[5]),
    .afhi_wmask  (wm[6])
  );

  assign wm[4] = '0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) begin
    for (int r = 0; r < 7; r++) begin
      cfg_q[r] <= (cfg_q[r] & ~wm[r]) | (bus_wdata & wm[r]);
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_bits(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      2'd2:    return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] frozen_bits(input int r, input logic [15:0] lk);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 16; i++) begin
      if (lk[i]) begin
        case (r)
          0, 2, 3: m[2*i +: 2] = 2'b11;
          1:       m[i] = 1'b1;
          5:       if (i < 8)  m[4*i +: 4] = 4'hF;
          6:       if (i >= 8) m[4*(i-8) +: 4] = 4'hF;
          default: ;
        endcase
      end
    end
    return m;
  endfunction

  function automatic logic [31:0] field_span(input int r);
    return (r == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic acc(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                     input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    bus_valid = 1'b1;
    bus_write = wr;
    bus_addr  = a;
    bus_size  = sz;
    bus_wdata = d;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1 bus_valid = 1'b0;
  endtask

  task automatic lock_wr(input logic key, input logic [15:0] m, input logic [1:0] sz = 2'd2);
    logic [31:0] rd;
    acc(1'b1, 3'd4, sz, {15'h0, key, m}, rd);
  endtask

  task automatic lock_rd(output logic [31:0] rd);
    acc(1'b0, 3'd4, 2'd2, 32'h0, rd);
  endtask

  task automatic cfg_wr(input string req, input int r, input logic [1:0] sz, input logic [31:0] d);
    logic [31:0] rd;
    logic [31:0] en;
    en = lane_bits(sz) & field_span(r) & ~frozen_bits(r, exp_lock);
    cfg_exp[r] = (cfg_exp[r] & ~en) | (d & en);
    acc(1'b1, r[2:0], sz, d, rd);
    @(negedge clk);
    chk(req, cfg_q[r], cfg_exp[r]);
  endtask

  task automatic all_cfg_writes(input string req, input logic [31:0] d);
    for (int r = 0; r < 7; r++) begin
      if (r != 4) cfg_wr(req, r, 2'd2, d);
    end
  endtask

  task automatic do_reset();
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_size  = '0;
    bus_wdata = '0;
    rst_n     = 1'b0;
    for (int r = 0; r < 7; r++) begin
      cfg_q[r]   = '0;
      cfg_exp[r] = '0;
    end
    exp_lock = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] rd;
    @(negedge clk);
    chk("R1 locked after reset", {16'h0, pin_locked}, 32'h0);
    lock_rd(rd);
    chk("R1 lock read after reset", rd, 32'h0);
  endtask

  task automatic t_open_writes();
    logic [31:0] rd;
    cfg_wr("R9 word write mode", 0, 2'd2, 32'hA5A5_5A5A);
    cfg_wr("R9 byte write speed", 2, 2'd0, 32'hFFFF_FFFF);
    cfg_wr("R9 half write pull", 3, 2'd1, 32'h1234_5678);
    cfg_wr("R9 otype upper half never written", 1, 2'd2, 32'hFFFF_FFFF);
    cfg_wr("R9 no-lane size", 5, 2'd3, 32'hFFFF_FFFF);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 3'd2; bus_size = 2'd2; bus_wdata = '1;
    #1;
    chk("R11 only speed mask", {wm[0] | wm[1] | wm[3] | wm[5] | wm[6]}, 32'h0);
    chk("R11 speed mask full", wm[2], 32'hFFFF_FFFF);
    bus_addr = 3'd4; bus_wdata = 32'h0;
    #1;
    chk("R11 lock write drives no mask",
        wm[0] | wm[1] | wm[2] | wm[3] | wm[5] | wm[6], 32'h0);
    bus_write = 1'b0; bus_addr = 3'd0;
    #1;
    chk("R11 read drives no mask",
        wm[0] | wm[1] | wm[2] | wm[3] | wm[5] | wm[6], 32'h0);
    @(posedge clk);
    #1 bus_valid = 1'b0;
    cfg_exp[2] = cfg_q[2];
    lock_rd(rd);
  endtask

  task automatic confirm_open(input string req);
    logic [31:0] rd;
    lock_rd(rd);
    chk({req, " read stays zero"}, rd, 32'h0);
    @(negedge clk);
    chk({req, " no pin locked"}, {16'h0, pin_locked}, 32'h0);
    cfg_wr({req, " mode still writable"}, 0, 2'd2, 32'h0F0F_F0F0);
  endtask

  task automatic t_abort_mask();
    lock_wr(1'b1, 16'h00FF);
    lock_wr(1'b0, 16'h00FE);
    lock_wr(1'b1, 16'h00FF);
    confirm_open("R4 mask change");
  endtask

  task automatic t_abort_narrow();
    lock_wr(1'b1, 16'h0F00);
    lock_wr(1'b0, 16'h0F00, 2'd1);
    lock_wr(1'b1, 16'h0F00);
    confirm_open("R5 half write");
    lock_wr(1'b1, 16'h0F00);
    lock_wr(1'b0, 16'h0F00);
    lock_wr(1'b1, 16'h0F00, 2'd0);
    confirm_open("R5 byte write");
  endtask

  task automatic t_abort_order();
    logic [31:0] rd;
    lock_wr(1'b1, 16'h3333);
    lock_wr(1'b0, 16'h3333);
    lock_rd(rd);
    lock_wr(1'b1, 16'h3333);
    confirm_open("R6 early read");
    lock_wr(1'b1, 16'h3333);
    lock_wr(1'b0, 16'h3333);
    lock_wr(1'b1, 16'h3333);
    lock_wr(1'b1, 16'h3333);
    confirm_open("R6 write instead of read");
    lock_wr(1'b1, 16'h3333);
    lock_wr(1'b1, 16'h3333);
    lock_wr(1'b1, 16'h3333);
    confirm_open("R6 wrong key value");
  endtask

  task automatic t_lock();
    logic [31:0] rd;
    lock_wr(1'b1, 16'h8101);
    cfg_wr("R7 interleaved write", 3, 2'd2, 32'h5555_AAAA);
    lock_wr(1'b0, 16'h8101);
    acc(1'b0, 3'd0, 2'd2, 32'h0, rd);
    lock_wr(1'b1, 16'h8101);
    cfg_wr("R7 interleaved write", 6, 2'd2, 32'h1111_2222);
    lock_rd(rd);
    chk("R2 arming read returns zero", rd, 32'h0);
    exp_lock = 16'h8101;
    @(negedge clk);
    chk("R3 R7 locked vector", {16'h0, pin_locked}, 32'h0000_8101);
    lock_rd(rd);
    chk("R2 read after arming", rd, 32'h0001_8101);
  endtask

  task automatic t_locked_writes();
    all_cfg_writes("R8 locked fields hold (ones)", 32'hFFFF_FFFF);
    all_cfg_writes("R8 locked fields hold (zeros)", 32'h0000_0000);
    all_cfg_writes("R8 R9 mixed pattern", 32'h9C3E_61A7);
    cfg_wr("R8 R9 byte write with lock", 0, 2'd0, 32'h0000_00FF);
  endtask

  task automatic t_relock();
    logic [31:0] rd;
    lock_wr(1'b1, 16'h00F0);
    lock_wr(1'b0, 16'h00F0);
    lock_wr(1'b1, 16'h00F0);
    lock_rd(rd);
    chk("R10 read unchanged", rd, 32'h0001_8101);
    @(negedge clk);
    chk("R10 locked vector unchanged", {16'h0, pin_locked}, 32'h0000_8101);
    lock_wr(1'b0, 16'h0000);
    lock_rd(rd);
    chk("R10 clearing write ignored", rd, 32'h0001_8101);
    cfg_wr("R10 pin 4 still open", 0, 2'd2, 32'h0000_0300);
  endtask

  task automatic t_reset_clears();
    logic [31:0] rd;
    do_reset();
    @(negedge clk);
    chk("R10 R1 reset clears lock", {16'h0, pin_locked}, 32'h0);
    lock_rd(rd);
    chk("R10 R1 read zero after reset", rd, 32'h0);
    all_cfg_writes("R10 all writable after reset", 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk  = 0;
    n_fail = 0;
    do_reset();
    t_reset();
    t_open_writes();
    t_abort_mask();
    t_abort_narrow();
    t_abort_order();
    t_lock();
    t_locked_writes();
    t_relock();
    t_reset_clears();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule